// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped station-management master for clause-22 PHY access. Software programs a PHY address and a register number. It then launches a frame. Writing the data register starts a write frame. Raising the read-command bit starts a read frame. The block serialises the 64-position frame on MDC/MDIO and reports progress in an indicator register. After a read completes, the returned 16 bits appear in a status register.

MDC is derived from the system clock by a programmable divider code. The configuration register holds both the divider code and a management-logic reset bit. Setting the reset bit aborts any frame in progress and blocks new launches for as long as it stays set. Register accesses are single-cycle write strobes with combinational read data.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and MDIO is not driven (mdio_oe = 0).
- R2: The configuration register (offset 0x20) holds the divider code in bits 3:0 and the management reset in bit 31. The target register (offset 0x28) holds the PHY address in bits 12:8 and the register number in bits 4:0. Both read back as written.
- R3: A write to the data register (offset 0x2c, value in bits 15:0) launches a write frame. The frame is 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits MSB first, with MDIO driven for all 64 positions.
- R4: A read frame uses opcode 10. MDIO is released from position 46 (turnaround) onwards, and positions 48..63 are sampled on MDC rising edges MSB first. The result appears in bits 15:0 of the status register (offset 0x30) when the frame ends.
- R5: For divider code N, MDC stays low for N+1 clocks and high for N+1 clocks. MDIO changes only together with a falling MDC edge, and MDC stays low while idle.
- R6: Indicator bit 0 (offset 0x34) is busy. It reads 1 from the cycle after a launching write until the falling MDC edge that ends position 63.
- R7: Indicator bit 2 is set when a read is launched and cleared when that read completes.
- R8: A read launches only when bit 0 of the command register (offset 0x24) goes from 0 to 1. Writing 1 while it already holds 1 starts nothing.
- R9: While busy, writes to the command and data registers are discarded. Their readback is unchanged, the running frame is unaffected and no further frame follows.
- R10: The PHY address and register number are captured at launch, so rewriting the target register mid-frame does not alter the frame.
- R11: Setting configuration bit 31 stops a running frame within two cycles, with busy 0, MDC low and MDIO released. No frame launches while the bit stays set. An aborted read leaves indicator bit 2 set and the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO input from the pad |

## Verification
The properties assume that each write strobe lasts one cycle with stable offset and data. They also assume that mdio_in changes only while MDC is low, well away from the rising edge at which the block samples it. The bench drives every register access from the falling system-clock edge. Its PHY model updates mdio_in only after a falling MDC edge, and the divider settings keep the MDC low phase at one clock or more. Aborts are issued through the configuration register, never by pulsing rst_n mid-frame, so the reset-disabled properties see one continuous run.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 8;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // positions in the serial frame
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(46);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(48);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_TARGET = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_DATA   = 8'h2c;
  localparam logic [ADDR_W-1:0] OFF_RESULT = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_IND    = 8'h34;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_target_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] code,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             hit;

  always_comb begin
    hit       = run && (cnt_q == code);
    tick_rise = hit && !mdc_q;
    tick_fall = hit && mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (hit) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             start_rd,
  input  mdio_target_t     tgt,
  input  logic [15:0]      wdata,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic             mdio_in,
  output logic             busy,
  output logic             rd_op,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic [15:0]      cap,
  output logic             mdio_out,
  output logic             mdio_oe
);
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [15:0]           cap_q, cap_d;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    sr_d   = sr_q;
    cap_d  = cap_q;
    done   = 1'b0;
    if (clr) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = start_rd;
      idx_d  = '0;
      cap_d  = '0;
      sr_d   = {32'hFFFF_FFFF, SOF_BITS, (start_rd ? OP_RD : OP_WR), tgt.phy, tgt.regn,
                (start_rd ? 2'b11 : TA_DRIVE), (start_rd ? 16'hFFFF : wdata)};
    end else if (busy_q) begin
      if (tick_rise && rd_q && (idx_q >= DATA_IDX)) begin
        cap_d = {cap_q[14:0], mdio_in};
      end
      if (tick_fall) begin
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          sr_d  = {sr_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sr_q   <= '1;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      sr_q   <= sr_d;
      cap_q  <= cap_d;
    end
  end

  assign busy     = busy_q;
  assign rd_op    = rd_q;
  assign idx      = idx_q;
  assign cap      = cap_q;
  assign mdio_out = sr_q[FRAME_BITS-1];
  assign mdio_oe  = busy_q && !(rd_q && (idx_q >= TA_IDX));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic rst_meta, rst_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  logic             cfg_rst_q, cfg_rst_d;
  logic [DIV_W-1:0] cfg_div_q, cfg_div_d;
  logic             cmd_q, cmd_d;
  mdio_target_t     tgt_q, tgt_d;
  logic [15:0]      data_q, data_d;
  logic [15:0]      result_q, result_d;
  logic             inval_q, inval_d;

  logic             busy, rd_op, done, mdc_rise, mdc_fall;
  logic [IDX_W-1:0] frm_idx;
  logic [15:0]      cap;
  logic             wr_cfg, wr_cmd, wr_tgt, wr_data;
  logic             start_wr, start_rd, launch;

  always_comb begin
    wr_cfg   = reg_wr && (reg_addr == OFF_CFG);
    wr_cmd   = reg_wr && (reg_addr == OFF_CMD);
    wr_tgt   = reg_wr && (reg_addr == OFF_TARGET);
    wr_data  = reg_wr && (reg_addr == OFF_DATA);
    start_wr = wr_data && !busy && !cfg_rst_q;
    start_rd = wr_cmd && !busy && !cfg_rst_q && reg_wdata[0] && !cmd_q;
    launch   = start_wr || start_rd;
  end

  always_comb begin
    cfg_rst_d = cfg_rst_q;
    cfg_div_d = cfg_div_q;
    cmd_d     = cmd_q;
    tgt_d     = tgt_q;
    data_d    = data_q;
    result_d  = result_q;
    inval_d   = inval_q;
    if (wr_cfg) begin
      cfg_rst_d = reg_wdata[REG_W-1];
      cfg_div_d = reg_wdata[DIV_W-1:0];
    end
    if (wr_cmd && !busy) cmd_d = reg_wdata[0];
    if (wr_tgt) begin
      tgt_d.phy  = reg_wdata[12:8];
      tgt_d.regn = reg_wdata[4:0];
    end
    if (wr_data && !busy) data_d = reg_wdata[15:0];
    if (start_rd) begin
      inval_d = 1'b1;
    end else if (done && rd_op) begin
      inval_d  = 1'b0;
      result_d = cap;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cfg_rst_q <= 1'b0;
      cfg_div_q <= '0;
      cmd_q     <= 1'b0;
      tgt_q     <= '0;
      data_q    <= '0;
      result_q  <= '0;
      inval_q   <= 1'b0;
    end else begin
      cfg_rst_q <= cfg_rst_d;
      cfg_div_q <= cfg_div_d;
      cmd_q     <= cmd_d;
      tgt_q     <= tgt_d;
      data_q    <= data_d;
      result_q  <= result_d;
      inval_q   <= inval_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFF_CFG:    reg_rdata = {cfg_rst_q, {(REG_W-1-DIV_W){1'b0}}, cfg_div_q};
      OFF_CMD:    reg_rdata = {{(REG_W-1){1'b0}}, cmd_q};
      OFF_TARGET: reg_rdata = {{(REG_W-13){1'b0}}, tgt_q.phy, 3'b000, tgt_q.regn};
      OFF_DATA:   reg_rdata = {{(REG_W-16){1'b0}}, data_q};
      OFF_RESULT: reg_rdata = {{(REG_W-16){1'b0}}, result_q};
      OFF_IND:    reg_rdata = {{(REG_W-3){1'b0}}, inval_q, 1'b0, busy};
      default:    reg_rdata = '0;
    endcase
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (busy && !cfg_rst_q),
    .code      (cfg_div_q),
    .mdc       (mdc),
    .tick_rise (mdc_rise),
    .tick_fall (mdc_fall)
  );

  mdio_frame_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_s),
    .clr       (cfg_rst_q),
    .start     (launch),
    .start_rd  (start_rd),
    .tgt       (tgt_q),
    .wdata     (reg_wdata[15:0]),
    .tick_rise (mdc_rise),
    .tick_fall (mdc_fall),
    .mdio_in   (mdio_in),
    .busy      (busy),
    .rd_op     (rd_op),
    .idx       (frm_idx),
    .done      (done),
    .cap       (cap),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_out,
  input logic             mdio_oe,
  input logic [IDX_W-1:0] idx,
  input logic             mgmt_rst,
  input logic             launch
);
  // R5: management clock parked low whenever no frame runs
  a_r5_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R5: data line moves only with a falling clock edge
  a_r5_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_out));

  // R3: line driven only inside a frame
  a_r3_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R6: launching write makes busy visible next cycle
  a_r6_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R6: frame position never steps backwards within a frame
  a_r6_idx_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx >= $past(idx)));

  // R11: management reset clears busy
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rst |=> !busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_s),
  .busy     (busy),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe),
  .idx      (frm_idx),
  .mgmt_rst (cfg_rst_q),
  .launch   (launch)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in;

  int n_chk  = 0;
  int n_fail = 0;
  int rises  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge mdc) rises++;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // behavioural PHY: expected frame bits, timing and read-data return
  task automatic check_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] dat, input int code);
    logic [63:0] exp;
    realtime t_r0, t_r, t_f;
    exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
           (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : dat)};
    mdio_in = 1'b1;
    t_r0 = 0.0;
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      t_r = $realtime;
      if (k == 0) t_r0 = t_r;
      if (k == 1) chk("R5 mdc period", int'((t_r - t_r0) / 5.0), 2 * (code + 1));
      #1;
      if (!rd || k < 46)
        chk(rd ? "R4 driven bit" : "R3 driven bit", {30'd0, mdio_oe, mdio_out}, {30'd0, 1'b1, exp[63-k]});
      else
        chk("R4 turnaround/data released", {31'd0, mdio_oe}, 32'd0);
      @(negedge mdc);
      t_f = $realtime;
      if (k == 0) chk("R5 mdc high time", int'((t_f - t_r) / 5.0), code + 1);
      mdio_in = (rd && (k + 1) >= 48 && (k + 1) <= 63) ? dat[63-(k+1)] : 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int r0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0; mdio_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(8'h20, d); chk("R1 cfg reset", d, 32'h0);
    bus_read(8'h24, d); chk("R1 cmd reset", d, 32'h0);
    bus_read(8'h28, d); chk("R1 target reset", d, 32'h0);
    bus_read(8'h30, d); chk("R1 result reset", d, 32'h0);
    bus_read(8'h34, d); chk("R1 indicator reset", d, 32'h0);
    chk("R1 mdc/oe idle", {30'd0, mdc, mdio_oe}, 32'd0);

    // R2 register layout
    bus_write(8'h20, 32'h0000_0001);
    bus_write(8'h28, 32'hFFFF_E5FA);
    bus_read(8'h28, d); chk("R2 target fields", d, 32'h0000_051A);
    bus_read(8'h20, d); chk("R2 cfg fields", d, 32'h0000_0001);

    // R3 write frame, R6 busy
    fork
      begin
        bus_write(8'h2c, 32'h0000_BEEF);
        bus_read(8'h34, d); chk("R6 busy after launch", d, 32'h1);
      end
      check_frame(1'b0, 5'h05, 5'h1A, 16'hBEEF, 1);
    join
    bus_read(8'h34, d); chk("R6 busy cleared at end", d, 32'h0);

    // R4 read frame, R7 invalid flag
    bus_write(8'h20, 32'h3);
    bus_write(8'h28, 32'h0000_1F00);
    bus_write(8'h24, 32'h0);
    fork
      begin
        bus_write(8'h24, 32'h1);
        bus_read(8'h34, d); chk("R7 invalid set during read", d, 32'h5);
      end
      check_frame(1'b1, 5'h1F, 5'h00, 16'hA5C3, 3);
    join
    bus_read(8'h30, d); chk("R4 read data", d, 32'h0000_A5C3);
    bus_read(8'h34, d); chk("R7 invalid cleared", d, 32'h0);

    // R8 held command bit does not relaunch
    r0 = rises;
    bus_write(8'h24, 32'h1);
    repeat (30) @(negedge clk);
    bus_read(8'h34, d); chk("R8 no relaunch busy", d, 32'h0);
    chk("R8 no mdc activity", rises, r0);

    // R9 discarded writes while busy, R10 target captured at launch
    bus_write(8'h24, 32'h0);
    bus_write(8'h28, 32'h0000_0A15);
    fork
      begin
        bus_write(8'h24, 32'h1);
        repeat (100) @(negedge clk);
        bus_write(8'h2c, 32'h0000_1234);
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'h0000_1F1F);
        bus_read(8'h2c, d); chk("R9 data write discarded", d, 32'h0000_BEEF);
        bus_read(8'h24, d); chk("R9 cmd write discarded", d, 32'h1);
      end
      check_frame(1'b1, 5'h0A, 5'h15, 16'h3C96, 3);
    join
    bus_read(8'h30, d); chk("R10 frame used launch target", d, 32'h0000_3C96);
    r0 = rises;
    repeat (60) @(negedge clk);
    chk("R9 no extra frame", rises, r0);
    bus_read(8'h28, d); chk("R10 target rewritten", d, 32'h0000_1F1F);

    // R5 fastest divider
    bus_write(8'h20, 32'h0);
    fork
      bus_write(8'h2c, 32'h0000_0001);
      check_frame(1'b0, 5'h1F, 5'h1F, 16'h0001, 0);
    join

    // R11 management reset
    bus_write(8'h20, 32'h2);
    bus_write(8'h28, 32'h0000_0301);
    bus_write(8'h24, 32'h0);
    bus_write(8'h24, 32'h1);
    repeat (60) @(negedge clk);
    bus_write(8'h20, 32'h8000_0002);
    @(negedge clk);
    bus_read(8'h34, d); chk("R11 aborted: busy 0, invalid kept", d, 32'h4);
    chk("R11 mdc low and released", {30'd0, mdc, mdio_oe}, 32'd0);
    bus_read(8'h30, d); chk("R11 result unchanged", d, 32'h0000_3C96);
    r0 = rises;
    bus_write(8'h2c, 32'h0000_55AA);
    repeat (20) @(negedge clk);
    bus_read(8'h34, d); chk("R11 no launch while held", d, 32'h4);
    chk("R11 mdc quiet while held", rises, r0);
    bus_write(8'h20, 32'h2);
    fork
      bus_write(8'h2c, 32'h0000_0F0F);
      check_frame(1'b0, 5'h03, 5'h01, 16'h0F0F, 2);
    join
    bus_read(8'h34, d); chk("R11 recovered frame done", d, 32'h4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule